// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a fast reference clock into the 16x oversampling strobe a UART bit engine needs. The rate is set in two stages. An integer pre-divider, chosen by a 3-bit code, produces a clock enable. A rate accumulator then adds (N+1) on each such enable. Whenever the sum reaches (D+1), it emits a one-cycle tick and subtracts (D+1). The long-run tick rate is therefore ref / ratio(code) x (N+1)/(D+1). With a ratio of 1 and N = 15, the bit rate is simply ref / (D+1).

Software writes the three settings through a small write port. A pre-divider write takes effect at once. The numerator is held in a shadow register. It becomes active together with the denominator only when a denominator write is the next write access after it. The configuration state machine has two states: `CFG_IDLE` (no numerator pending) and `CFG_ARMED` (a numerator is waiting in the shadow register). Its transitions are:
- *arm*: `CFG_IDLE`→`CFG_ARMED` on a numerator write.
- *rearm*: `CFG_ARMED`→`CFG_ARMED` on another numerator write, which replaces the shadow.
- *commit*: `CFG_ARMED`→`CFG_IDLE` on a denominator write.
- *abandon*: `CFG_ARMED`→`CFG_IDLE` on any other write.

The active settings are driven back out for readback.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the active pre-divider code is 5, N is 15 and D is 0, and a tick is produced on every reference cycle.
- R2: The pre-divider code maps to a divide ratio: 0→6, 1→5, 2→4, 3→3, 4→2, 5→1, 6→7, 7→1.
- R3: When N ≤ D, the number of ticks over any window of ratio x K reference cycles is within 1 of K x (N+1)/(D+1).
- R4: When N > D, a tick is produced on every pre-divider enable, which gives K ticks in ratio x K cycles.
- R5: A numerator write (wr_sel = 1) whose next write access is not a denominator write changes neither the readback nor the tick rate, and its value is discarded.
- R6: A denominator write (wr_sel = 2) whose preceding write access was a numerator write loads both values into the active registers. Idle cycles between the two writes are allowed. Readback shows the pair one cycle after the denominator write, and the accumulator restarts from zero.
- R7: A denominator write that does not directly follow a numerator write is ignored.
- R8: A pre-divider write (wr_sel = 0, code in wr_data[2:0]) is active and visible on readback one cycle later, and it restarts the pre-divider count. wr_sel = 3 writes nothing but ends a pending numerator.
- R9: With code 5 and N = 15, the tick rate is 16 x ref / (D+1) for D ≥ 15, so the bit rate is ref / (D+1).
- R10: Each tick lasts one cycle. When the pre-divide ratio exceeds 1, two ticks are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| wr_sel | input | 2 | Target: 0 pre-divider, 1 numerator, 2 denominator, 3 none |
| wr_data | input | RATE_W | Write value |
| tick_o | output | 1 | One-cycle 16x oversampling strobe |
| prediv_o | output | 3 | Active pre-divider code |
| num_o | output | RATE_W | Active numerator register (N) |
| den_o | output | RATE_W | Active denominator register (D) |

## Verification
The hardest case to reach is the write-order rule. A numerator must be abandoned by an intervening pre-divider or null write, and the denominator write that follows must then leave the rate untouched. Idle gaps inside a valid pair must still commit it. Directed sequences build each of these orderings, and the bench then measures the rate over a long window. This shows that a discarded shadow value never leaks into the accumulator. Random settings sweep all eight pre-divider codes across both the N ≤ D and N > D regions.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        SEL_PREDIV = 2'd0,
        SEL_NUM    = 2'd1,
        SEL_DEN    = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    typedef enum logic {
        CFG_IDLE  = 1'b0,
        CFG_ARMED = 1'b1
    } cfg_state_e;

    localparam logic [2:0] RESET_CODE = 3'd5;

    function automatic logic [2:0] prediv_ratio(input logic [2:0] code);
        logic [2:0] r;
        unique case (code)
            3'd0: r = 3'd6;
            3'd1: r = 3'd5;
            3'd2: r = 3'd4;
            3'd3: r = 3'd3;
            3'd4: r = 3'd2;
            3'd6: r = 3'd7;
            default: r = 3'd1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bt_cfg.sv
module bt_cfg
    import bt_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output logic [2:0]        code_q,
    output logic [RATE_W-1:0] num_q,
    output logic [RATE_W-1:0] den_q,
    output logic              code_load,
    output logic              pair_load
);
    localparam logic [RATE_W-1:0] RESET_NUM = RATE_W'(15);

    cfg_state_e        state_q, state_d;
    logic [RATE_W-1:0] shadow_q;
    wr_sel_e           sel;

    assign sel = wr_sel_e'(wr_sel);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // Next state and load strobes
    always_comb begin
        state_d   = state_q;
        code_load = wr_en && (sel == SEL_PREDIV);
        pair_load = 1'b0;
        unique case (state_q)
            CFG_IDLE: begin
                if (wr_en && sel == SEL_NUM) state_d = CFG_ARMED;
            end
            CFG_ARMED: begin
                if (wr_en) begin
                    if (sel == SEL_NUM) begin
                        state_d = CFG_ARMED;
                    end else begin
                        state_d   = CFG_IDLE;
                        pair_load = (sel == SEL_DEN);
                    end
                end
            end
            default: state_d = CFG_IDLE;
        endcase
    end

    // Setting registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= RESET_CODE;
            num_q    <= RESET_NUM;
            den_q    <= '0;
            shadow_q <= RESET_NUM;
        end else begin
            if (wr_en && sel == SEL_NUM) shadow_q <= wr_data;
            if (code_load) code_q <= wr_data[2:0];
            if (pair_load) begin
                num_q <= shadow_q;
                den_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/bt_prediv.sv
module bt_prediv
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    input  logic       restart,
    output logic       en
);
    logic [2:0] cnt_q;
    logic [2:0] last;

    assign last = prediv_ratio(code) - 3'd1;
    assign en   = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (en)           cnt_q <= '0;
        else                   cnt_q <= cnt_q + 3'd1;
    end
endmodule

// File: rtl/bt_rate_acc.sv
module bt_rate_acc #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clear,
    input  logic [RATE_W-1:0] num,
    input  logic [RATE_W-1:0] den,
    output logic              tick
);
    localparam logic [RATE_W:0] ONE = {{RATE_W{1'b0}}, 1'b1};

    logic [RATE_W:0] acc_q, sum, step_up, step_dn;
    logic            hit, saturate;

    assign step_up  = {1'b0, num} + ONE;
    assign step_dn  = {1'b0, den} + ONE;
    assign sum      = acc_q + step_up;
    assign hit      = (sum >= step_dn);
    assign saturate = (num > den);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (en) begin
            tick <= hit;
            if (saturate)  acc_q <= '0;
            else if (hit)  acc_q <= sum - step_dn;
            else           acc_q <= sum;
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output logic              tick_o,
    output logic [2:0]        prediv_o,
    output logic [RATE_W-1:0] num_o,
    output logic [RATE_W-1:0] den_o
);
    logic code_load, pair_load, pre_en;

    bt_cfg #(.RATE_W(RATE_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .code_q    (prediv_o),
        .num_q     (num_o),
        .den_q     (den_o),
        .code_load (code_load),
        .pair_load (pair_load)
    );

    bt_prediv i_prediv (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (prediv_o),
        .restart (code_load),
        .en      (pre_en)
    );

    bt_rate_acc #(.RATE_W(RATE_W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pre_en),
        .clear (pair_load),
        .num   (num_o),
        .den   (den_o),
        .tick  (tick_o)
    );
endmodule

// File: rtl/bt_checker.sv
module bt_checker
    import bt_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [RATE_W-1:0] wr_data,
    input logic              tick_o,
    input logic [2:0]        prediv_o,
    input logic [RATE_W-1:0] num_o,
    input logic [RATE_W-1:0] den_o
);
    logic              ch_armed;
    logic [RATE_W-1:0] ch_shadow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_armed  <= 1'b0;
            ch_shadow <= '0;
        end else if (wr_en) begin
            ch_armed <= (wr_sel == 2'd1);
            if (wr_sel == 2'd1) ch_shadow <= wr_data;
        end
    end

    p_pair_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && ch_armed)
        |=> (num_o == $past(ch_shadow) && den_o == $past(wr_data)));

    p_lone_num_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd2) |=> ($stable(num_o) && $stable(den_o)));

    p_den_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !ch_armed) |=> ($stable(num_o) && $stable(den_o)));

    p_prediv_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (prediv_o == $past(wr_data[2:0])));

    p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && prediv_ratio(prediv_o) != 3'd1 && $stable(prediv_o)) |=> !tick_o);
endmodule

bind baud_tick_gen bt_checker #(.RATE_W(RATE_W)) i_bt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tick_o   (tick_o),
    .prediv_o (prediv_o),
    .num_o    (num_o),
    .den_o    (den_o)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         tick_o;
    logic [2:0]   prediv_o;
    logic [W-1:0] num_o, den_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen #(.RATE_W(W)) i_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick_o(tick_o), .prediv_o(prediv_o),
        .num_o(num_o), .den_o(den_o)
    );

    function automatic int exp_ratio(input int code);
        case (code)
            0: return 6;
            1: return 5;
            2: return 4;
            3: return 3;
            4: return 2;
            6: return 7;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int code, input int n, input int d);
        wr(0, code);
        wr(1, n);
        wr(2, d);
        check(prediv_o == 3'(code), "R8 prediv readback", prediv_o, code);
        check(num_o == W'(n) && den_o == W'(d), "R6 pair readback", num_o, n);
    endtask

    task automatic measure(input int code, input int n, input int d, input int k, input string req);
        int p = exp_ratio(code);
        longint ticks = 0;
        longint err, tol;
        int adj = 0;
        bit prev = 1'b0;
        repeat (16) @(negedge clk);
        for (int c = 0; c < p * k; c++) begin
            @(negedge clk);
            if (tick_o) ticks++;
            if (tick_o && prev) adj++;
            prev = tick_o;
        end
        if (n <= d) begin
            err = ticks * (d + 1) - longint'(k) * (n + 1);
            tol = d + 1;
            check(err <= tol && err >= -tol, req, ticks, (longint'(k) * (n + 1)) / (d + 1));
        end else begin
            check(ticks >= k - 1 && ticks <= k + 1, req, ticks, k);
        end
        if (p > 1) check(adj == 0, "R10 adjacent ticks", adj, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(prediv_o == 3'd5, "R1 prediv", prediv_o, 5);
        check(num_o == 16'd15, "R1 num", num_o, 15);
        check(den_o == 16'd0, "R1 den", den_o, 0);
        measure(5, 15, 0, 100, "R1 tick every cycle");

        // R2 every pre-divider code
        for (int c = 0; c < 8; c++) begin
            setup(c, 0, 0);
            measure(c, 0, 0, 200, "R2 code ratio");
        end

        // R9 integer mode
        setup(5, 15, 99);
        measure(5, 15, 99, 1600, "R9 integer divisor");
        setup(5, 15, 15);
        measure(5, 15, 15, 300, "R9 divisor 16");

        // R4 numerator above denominator
        setup(2, 9, 3);
        measure(2, 9, 3, 300, "R4 saturate");

        // R5 and R7: abandoned numerator, then stray denominator
        setup(5, 0, 3);
        wr(1, 3);
        check(num_o == 16'd0, "R5 lone num readback", num_o, 0);
        wr(0, 5);
        wr(2, 0);
        check(den_o == 16'd3 && num_o == 16'd0, "R7 stray den readback", den_o, 3);
        measure(5, 0, 3, 400, "R5 rate unchanged");
        wr(1, 7);
        wr(3, 0);
        wr(2, 9);
        check(den_o == 16'd3, "R8 null write ends pair", den_o, 3);
        wr(2, 1);
        check(den_o == 16'd3, "R7 den after commit", den_o, 3);

        // R6 idle gap and repeated numerator
        wr(1, 4);
        repeat (5) @(negedge clk);
        wr(2, 9);
        check(num_o == 16'd4 && den_o == 16'd9, "R6 gap commit", num_o, 4);
        wr(1, 100);
        wr(1, 2);
        wr(2, 6);
        check(num_o == 16'd2 && den_o == 16'd6, "R6 last num wins", num_o, 2);
        measure(5, 2, 6, 700, "R6 rate after commit");

        // R3 random settings
        for (int i = 0; i < 14; i++) begin
            int code = int'($urandom % 8);
            int d = int'($urandom % 500);
            int n = (i % 5 == 4) ? d + 1 + int'($urandom % 20) : int'($urandom % (d + 1));
            setup(code, n, d);
            measure(code, n, d, 400, n <= d ? "R3 random rate" : "R4 random saturate");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule